// File: doc/BRIEF.md
# Three-Dimensional Strided Address Generator

This block turns one transfer descriptor into the ordered stream of byte addresses that a data mover needs. The descriptor gives a source start address, a destination start address, a row length in bytes, a row count per plane, a plane count, and four signed 16-bit strides. Each side has one stride between rows and one stride between planes. Within a row both addresses advance by one byte per beat. A new row starts at the previous row start plus that side's row stride. A new plane starts at the previous plane's first row plus that side's plane stride.

The two sides are walked independently, so one descriptor can express row-to-column transposes, gathers of a sub-rectangle from a wider grid, or scatters to a fixed port (both strides zero). Each address pair is offered on a valid/ready beat interface. A single-cycle completion pulse follows the last accepted beat. The generator uses running row-start and plane-start registers on each side, so it needs no multiplier. The descriptor is captured when a transfer starts.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset `beat_valid` and `xfer_done` are low until a start is accepted.
- R2: Within a row, each accepted beat is followed by a beat whose source and destination addresses are both one greater than the last, modulo 2^32.
- R3: The first beat of each row after the first in a plane is at the previous row start plus that side's row stride. Source and destination use their own strides.
- R4: The first beat of each plane after the first is at the first row start of the previous plane plus that side's plane stride.
- R5: A transfer presents exactly row_len × rows × planes beats, in row-major order: byte index fastest, then row, then plane.
- R6: If any of the three counts is zero when a start is accepted, no beat is presented and `xfer_done` is high in the cycle after the start.
- R7: `xfer_done` is high for one cycle, in the cycle after the final beat is accepted. `beat_valid` is low in that cycle.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_valid` stays high and both addresses hold their values.
- R9: A start strobe that arrives while a transfer is running, including in the cycle its final beat is accepted, has no effect. It produces neither extra beats nor extra completion pulses.
- R10: The descriptor inputs are sampled in the cycle a start is accepted. Later changes to them do not affect the running transfer.
- R11: Strides are two's-complement 16-bit values in the range -32768 to 32767. They are sign-extended to 32 bits, and address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| src_base | input | 32 | Source start address |
| dst_base | input | 32 | Destination start address |
| row_len | input | 16 | Contiguous bytes per row |
| row_cnt | input | 16 | Rows per plane |
| plane_cnt | input | 16 | Planes per transfer |
| src_row_step | input | 16 | Signed source row stride |
| dst_row_step | input | 16 | Signed destination row stride |
| src_plane_step | input | 16 | Signed source plane stride |
| dst_plane_step | input | 16 | Signed destination plane stride |
| beat_valid | output | 1 | Address pair offered |
| beat_ready | input | 1 | Consumer accepts the pair |
| beat_src | output | 32 | Source byte address |
| beat_dst | output | 32 | Destination byte address |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same clock edge: the acceptance of the final beat, which ends the transfer and schedules the completion pulse, and a new start strobe. The bench raises `start` throughout the stall and accept cycles of the final beat, and also early in the transfer, in runs with random back-pressure. It then requires exactly one completion pulse, no beat after it, and an idle interface in the following cycle. In the same runs the descriptor inputs are changed right after the start, and the bench requires every address to match the values captured at the start.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;
  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } gen_state_e;

  localparam int NUM_DIMS  = 3;  // byte, row, plane
  localparam int NUM_SIDES = 2;  // source, destination
endpackage

// File: rtl/dma3d_dim_ctr.sv
module dma3d_dim_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             en;

  assign last = (idx_q == (lim_q - ONE));
  assign en   = load | inc;

  always_comb begin
    idx_d = idx_q;
    lim_d = lim_q;
    if (load) begin
      idx_d = '0;
      lim_d = limit;
    end else if (inc) begin
      idx_d = last ? '0 : (idx_q + ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      lim_q <= '0;
    end else if (en) begin
      idx_q <= idx_d;
      lim_q <= lim_d;
    end
  end

  // R5: while running, the position never reaches the captured count
  a_r5_idx_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx_q < lim_q));
endmodule

// File: rtl/dma3d_side_walk.sv
module dma3d_side_walk #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   base,
  input  logic [STRIDE_W-1:0] row_stride,
  input  logic [STRIDE_W-1:0] plane_stride,
  input  logic                step_byte,
  input  logic                step_row,
  input  logic                step_plane,
  output logic [ADDR_W-1:0]   addr
);
  localparam int              EXT_W = ADDR_W - STRIDE_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [STRIDE_W-1:0] rs_q, rs_d, ps_q, ps_d;
  logic [ADDR_W-1:0]   plane_q, plane_d, row_q, row_d, cur_q, cur_d;
  logic [ADDR_W-1:0]   rs_x, ps_x, plane_nxt, row_nxt;
  logic                en;

  // R11: sign extension of the 16-bit strides
  assign rs_x      = {{EXT_W{rs_q[STRIDE_W-1]}}, rs_q};
  assign ps_x      = {{EXT_W{ps_q[STRIDE_W-1]}}, ps_q};
  assign plane_nxt = plane_q + ps_x;
  assign row_nxt   = row_q + rs_x;
  assign en        = load | step_byte | step_row | step_plane;
  assign addr      = cur_q;

  always_comb begin
    rs_d    = rs_q;
    ps_d    = ps_q;
    plane_d = plane_q;
    row_d   = row_q;
    cur_d   = cur_q;
    if (load) begin
      rs_d    = row_stride;
      ps_d    = plane_stride;
      plane_d = base;
      row_d   = base;
      cur_d   = base;
    end else if (step_plane) begin
      plane_d = plane_nxt;
      row_d   = plane_nxt;
      cur_d   = plane_nxt;
    end else if (step_row) begin
      row_d = row_nxt;
      cur_d = row_nxt;
    end else if (step_byte) begin
      cur_d = cur_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q    <= '0;
      ps_q    <= '0;
      plane_q <= '0;
      row_q   <= '0;
      cur_q   <= '0;
    end else if (en) begin
      rs_q    <= rs_d;
      ps_q    <= ps_d;
      plane_q <= plane_d;
      row_q   <= row_d;
      cur_q   <= cur_d;
    end
  end

  // R4: at most one kind of step is requested per cycle
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, step_byte, step_row, step_plane}));
endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   src_base,
  input  logic [ADDR_W-1:0]   dst_base,
  input  logic [CNT_W-1:0]    row_len,
  input  logic [CNT_W-1:0]    row_cnt,
  input  logic [CNT_W-1:0]    plane_cnt,
  input  logic [STRIDE_W-1:0] src_row_step,
  input  logic [STRIDE_W-1:0] dst_row_step,
  input  logic [STRIDE_W-1:0] src_plane_step,
  input  logic [STRIDE_W-1:0] dst_plane_step,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [ADDR_W-1:0]   beat_src,
  output logic [ADDR_W-1:0]   beat_dst,
  output logic                xfer_done
);
  import dma3d_pkg::*;

  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  gen_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       fire, start_ok, zero_cnt, load, running;

  logic [CNT_W-1:0]    lim_in   [NUM_DIMS];
  logic [NUM_DIMS-1:0] last;
  logic [NUM_DIMS:0]   carry;

  logic [ADDR_W-1:0]   side_base  [NUM_SIDES];
  logic [STRIDE_W-1:0] side_rstep [NUM_SIDES];
  logic [STRIDE_W-1:0] side_pstep [NUM_SIDES];
  logic [ADDR_W-1:0]   side_addr  [NUM_SIDES];

  assign running   = (state_q == GEN_RUN);
  assign beat_valid = running;
  assign fire      = running & beat_ready;
  assign zero_cnt  = (row_len == '0) | (row_cnt == '0) | (plane_cnt == '0);
  assign start_ok  = start & (state_q == GEN_IDLE);
  assign load      = start_ok & ~zero_cnt;

  assign lim_in[0] = row_len;
  assign lim_in[1] = row_cnt;
  assign lim_in[2] = plane_cnt;

  // Carry chain: dimension d advances when all faster dimensions wrap
  assign carry[0] = fire;
  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    assign carry[d+1] = carry[d] & last[d];
    dma3d_dim_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .active (running),
      .inc    (carry[d]),
      .limit  (lim_in[d]),
      .last   (last[d])
    );
  end

  assign side_base[0]  = src_base;
  assign side_base[1]  = dst_base;
  assign side_rstep[0] = src_row_step;
  assign side_rstep[1] = dst_row_step;
  assign side_pstep[0] = src_plane_step;
  assign side_pstep[1] = dst_plane_step;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    dma3d_side_walk #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .base         (side_base[s]),
      .row_stride   (side_rstep[s]),
      .plane_stride (side_pstep[s]),
      .step_byte    (carry[0] & ~last[0]),
      .step_row     (carry[1] & ~last[1]),
      .step_plane   (carry[2] & ~last[2]),
      .addr         (side_addr[s])
    );
  end

  assign beat_src  = side_addr[0];
  assign beat_dst  = side_addr[1];
  assign xfer_done = done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      GEN_IDLE: if (load)            state_d = GEN_RUN;
      GEN_RUN:  if (carry[NUM_DIMS]) state_d = GEN_IDLE;
      default:                       state_d = GEN_IDLE;
    endcase
    done_d = (start_ok & zero_cnt) | carry[NUM_DIMS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GEN_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R2: inside a row both pointers move by one byte
  a_r2_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last[0]) |=> (beat_src == $past(beat_src) + ONE_A) &&
                           (beat_dst == $past(beat_dst) + ONE_A));

  // R8: a stalled beat is held
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_src) && $stable(beat_dst));

  // R7: completion is only signalled when nothing is offered
  a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !beat_valid);

  // R9: start during a transfer that is not ending changes nothing visible
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && start && !(beat_ready && last[0] && last[1] && last[2]))
      |=> beat_valid && !xfer_done);

  // R6: empty descriptor completes at once with no beat
  a_r6_zero_no_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !beat_valid && zero_cnt) |=> xfer_done && !beat_valid);
endmodule

// File: tb/dma3d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma3d_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] src_base, dst_base;
  logic [15:0] row_len, row_cnt, plane_cnt;
  logic [15:0] src_row_step, dst_row_step, src_plane_step, dst_plane_step;
  logic        beat_valid, beat_ready, xfer_done;
  logic [31:0] beat_src, beat_dst;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  dma3d_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .row_len(row_len), .row_cnt(row_cnt), .plane_cnt(plane_cnt),
    .src_row_step(src_row_step), .dst_row_step(dst_row_step),
    .src_plane_step(src_plane_step), .dst_plane_step(dst_plane_step),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_src(beat_src), .beat_dst(beat_dst), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected address of beat n on one side (R2, R3, R4, R5, R11)
  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int n,
      input int a, input int b, input int rstep, input int pstep);
    int ia, ib, ic;
    ia = n % a;
    ib = (n / a) % b;
    ic = n / (a * b);
    return base + 32'(ic * pstep) + 32'(ib * rstep) + 32'(ia);
  endfunction

  task automatic run_xfer(input logic [31:0] sb, input logic [31:0] db,
      input int a, input int b, input int c,
      input int srs, input int drs, input int sps, input int dps,
      input int rdy_pct, input bit poke, input string tag);
    int   total, n;
    bit   got_done, r, prev_v, prev_r;
    logic [31:0] prev_s, prev_d, es, ed;
    total = a * b * c;
    n = 0; got_done = 0; prev_v = 0; prev_r = 0; prev_s = '0; prev_d = '0;
    @(negedge clk);
    src_base = sb; dst_base = db;
    row_len = 16'(a); row_cnt = 16'(b); plane_cnt = 16'(c);
    src_row_step = 16'(srs); dst_row_step = 16'(drs);
    src_plane_step = 16'(sps); dst_plane_step = 16'(dps);
    start = 1'b1;
    beat_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R10: disturb descriptor after capture
      src_base = ~sb; dst_base = sb ^ db;
      row_len = 16'(a + 3); row_cnt = 16'd0; plane_cnt = 16'(c + 1);
      src_row_step = 16'(srs + 7); dst_row_step = 16'(drs - 9);
      src_plane_step = 16'(sps + 100); dst_plane_step = 16'(dps + 1);
    end
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (xfer_done) begin got_done = 1; break; end
      if (prev_v && !prev_r)
        chk(beat_valid && beat_src == prev_s && beat_dst == prev_d, "R8",
            {tag, " stall hold"}, {beat_src, beat_dst}, {prev_s, prev_d});
      r = ($urandom_range(99) < rdy_pct);
      start = poke && (n == 1 || n == total - 1);  // R9 stimulus
      beat_ready = r;
      if (beat_valid && r) begin
        es = exp_addr(sb, n, a, b, srs, sps);
        ed = exp_addr(db, n, a, b, drs, dps);
        chk(beat_src == es && beat_dst == ed, "R2/R3/R4/R11",
            $sformatf("%s beat %0d", tag, n), {beat_src, beat_dst}, {es, ed});
        n++;
      end
      prev_v = beat_valid; prev_r = r; prev_s = beat_src; prev_d = beat_dst;
      @(negedge clk);
    end
    start = 1'b0;
    beat_ready = 1'b0;
    chk(got_done, "R7", {tag, " done seen"}, 64'(got_done), 64'd1);
    chk(n == total, "R5", {tag, " beat count"}, 64'(n), 64'(total));
    chk(!beat_valid, "R7", {tag, " valid low with done"}, 64'(beat_valid), 64'd0);
    @(negedge clk);
    chk(!xfer_done && !beat_valid, "R9", {tag, " idle after done"},
        {62'd0, xfer_done, beat_valid}, 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; beat_ready = 1'b0;
    src_base = '0; dst_base = '0; row_len = '0; row_cnt = '0; plane_cnt = '0;
    src_row_step = '0; dst_row_step = '0; src_plane_step = '0; dst_plane_step = '0;
    repeat (3) @(negedge clk);
    chk(!beat_valid && !xfer_done, "R1", "in reset", {beat_valid, xfer_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!beat_valid && !xfer_done, "R1", "after reset", {beat_valid, xfer_done}, 0);

    // R4: 4x4 tile of 16-bit pixels from a 12-byte-wide grid to a fixed port
    run_xfer(32'h0000_1000, 32'h4000_0000, 2, 4, 4, 2, 0, 12, 0, 100, 0, "R4 tile");
    // R5: same four bytes as one row or as four one-byte rows
    run_xfer(32'h0000_0008, 32'h0000_2000, 4, 1, 1, 0, 0, 0, 0, 100, 0, "R5 one row");
    run_xfer(32'h0000_0008, 32'h0000_2000, 1, 4, 1, 1, 1, 0, 0, 70, 0, "R5 four rows");
    // R3: row to column, independent strides
    run_xfer(32'h0000_0100, 32'h0000_0200, 1, 4, 1, 1, 6, 0, 0, 100, 0, "R3 column");
    // R6: each count zero in turn
    run_xfer(32'h10, 32'h20, 0, 3, 3, 1, 1, 1, 1, 100, 0, "R6 row_len zero");
    run_xfer(32'h10, 32'h20, 3, 0, 3, 1, 1, 1, 1, 100, 0, "R6 row_cnt zero");
    run_xfer(32'h10, 32'h20, 3, 3, 0, 1, 1, 1, 1, 100, 0, "R6 plane_cnt zero");
    // R11: extreme strides, wrap below zero
    run_xfer(32'h0000_0010, 32'hFFFF_FFF0, 3, 3, 2, -32768, 32767, -5, -32768, 50, 0, "R11 extremes");
    // R9 and R10: start pokes and descriptor changes while running
    run_xfer(32'h0000_3000, 32'h0000_5000, 3, 2, 2, 10, -4, 40, 100, 40, 1, "R9 R10 poke");

    for (int i = 0; i < 25; i++) begin
      run_xfer($urandom(), $urandom(),
               int'($urandom_range(4, 1)), int'($urandom_range(4, 1)),
               int'($urandom_range(3, 1)),
               int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
               int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768,
               int'($urandom_range(100, 30)), bit'($urandom_range(1)),
               $sformatf("R5 random %0d", i));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule